// File: doc/BRIEF.md
# PMP Entry Configuration Bank with WARL Legalisation

This block holds the protection-entry configuration bytes of a small RISC-V core. Each entry is one byte, and four entries share one 32-bit CSR word. Software writes a word through a strobed port that carries a word index, the data and a four-bit byte enable. Every enabled byte is legalised field by field before it is stored. Fields that hold an illegal value are discarded and keep their old contents. No exception or error indication is produced. A combinational read port returns any word. All entry bytes are also driven in parallel to the access checker that sits downstream.

Only two address-matching modes exist: OFF and TOR. The legality of the mode field and of the permission triple is tested against an explicit set of allowed values. They are not masked toward a neighbouring value, so a rejected write can never land on a mode that software did not ask for. A build parameter removes protection altogether. In that build every mode field reads as zero and cannot be changed.

Top module: `pmpcfg_bank`

## Requirements
- R1: After a synchronous reset every entry byte is 8'h00 (mode OFF, no permissions, unlocked), on both the read port and `entry_cfg`.
- R2: Entry byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode, bit 7 lock. Entry k of word i sits in bits 8k+7:8k of the word and in `entry_cfg[8(4i+k)+7 : 8(4i+k)]`. A write with the strobe high is stored at the next rising edge and is visible on both outputs from that edge on.
- R3: Only the lanes whose `csr_wbe` bit is set are written. Other lanes, and all other words, are left unchanged.
- R4: The mode field accepts only 2'b00 (OFF) and 2'b01 (TOR). A written mode with bit 4 set is discarded and the previous mode is kept, so writing 2'b11 over OFF leaves OFF. The other fields of that byte are still legalised and stored.
- R5: A permission triple with write=1 and read=0 is reserved. Such a write keeps the previous read, write and execute bits, while the mode and lock fields of the byte are still stored.
- R6: Once an entry's lock bit is set, every write to that byte is ignored until reset.
- R7: Legalisation is per byte: an illegal field in one lane does not hinder a legal update of another lane in the same write.
- R8: Bits 6:5 of every entry always read as zero, whatever is written.
- R9: With `PMP_OFF` = 1 every mode field reads zero and mode writes are ignored. The remaining fields behave as in R2 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe |
| csr_widx | input | WIDX_W | Word index of the write |
| csr_wdata | input | 32 | Write data, four entry bytes |
| csr_wbe | input | 4 | Per-lane byte enable |
| csr_ridx | input | WIDX_W | Word index of the read |
| csr_rdata | output | 32 | Read data for `csr_ridx` (zero when out of range) |
| entry_cfg | output | 8*NUM_ENTRIES | All stored entry bytes, entry 0 at the bottom |

## Verification
The assertions assume that the write strobe, index, data and enables are known, 0 or 1 values whenever reset is low, and that reset is taken before the first write. The bench drives every input on the falling edge and holds reset for several cycles at the start. It only ever writes word indices inside the bank. Every check is made after the rising edge that stores the write, so the stimulus never races the capture edge that the hold and lock properties reason about.

// File: rtl/pmpcfg_pkg.sv
package pmpcfg_pkg;

  localparam int BYTE_W   = 8;
  localparam int LANES    = 4;
  localparam int BIT_R    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_X    = 2;
  localparam int MODE_LO  = 3;
  localparam int MODE_HI  = 4;
  localparam int RSV_LO   = 5;
  localparam int RSV_HI   = 6;
  localparam int BIT_L    = 7;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_TOR   = 2'b01,
    MODE_NA4   = 2'b10,
    MODE_NAPOT = 2'b11
  } match_mode_e;

  // Explicit allowed set for the mode field.
  function automatic logic mode_allowed(input logic [1:0] m);
    case (match_mode_e'(m))
      MODE_OFF, MODE_TOR: mode_allowed = 1'b1;
      default:            mode_allowed = 1'b0;
    endcase
  endfunction

  // Explicit allowed set for the {X,W,R} triple.
  function automatic logic perm_allowed(input logic [2:0] xwr);
    case (xwr)
      3'b000, 3'b001, 3'b011, 3'b100, 3'b101, 3'b111: perm_allowed = 1'b1;
      default:                                         perm_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmpcfg_legalize.sv
module pmpcfg_legalize
  import pmpcfg_pkg::*;
#(
  parameter bit PMP_OFF = 1'b0
) (
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] nxt_byte
);

  localparam logic [RSV_HI-RSV_LO:0] RSV_KEEP = '0;

  logic [2:0] wr_perm;
  logic [1:0] wr_mode;

  assign wr_perm = wr_byte[BIT_X:BIT_R];
  assign wr_mode = wr_byte[MODE_HI:MODE_LO];

  always_comb begin
    nxt_byte = cur_byte;
    if (!cur_byte[BIT_L]) begin
      if (perm_allowed(wr_perm)) begin
        nxt_byte[BIT_X:BIT_R] = wr_perm;
      end
      if (PMP_OFF) begin
        nxt_byte[MODE_HI:MODE_LO] = MODE_OFF;
      end else if (mode_allowed(wr_mode)) begin
        nxt_byte[MODE_HI:MODE_LO] = wr_mode;
      end
      nxt_byte[RSV_HI:RSV_LO] = wr_byte[RSV_HI:RSV_LO] & RSV_KEEP;
      nxt_byte[BIT_L]         = wr_byte[BIT_L];
    end
  end

endmodule

// File: rtl/pmpcfg_entry.sv
module pmpcfg_entry
  import pmpcfg_pkg::*;
#(
  parameter bit PMP_OFF = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] nxt_byte,
  output logic [BYTE_W-1:0] cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_hit) begin
      cfg_q <= nxt_byte;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_q[MODE_HI] == 1'b0);

  assert_bad_mode_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(wr_hit && wr_byte[MODE_HI]))
      |-> (cfg_q[MODE_HI:MODE_LO] == $past(cfg_q[MODE_HI:MODE_LO])));

  assert_perm_legal_R5: assert property (@(posedge clk) disable iff (rst)
    !(cfg_q[BIT_W] && !cfg_q[BIT_R]));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(wr_hit)) |-> (cfg_q == $past(cfg_q)));

  assert_lock_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(cfg_q[BIT_L])) |-> (cfg_q == $past(cfg_q)));

  assert_rsv_zero_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_q[RSV_HI:RSV_LO] == '0);

  if (PMP_OFF) begin : g_off_chk
    assert_mode_zero_R9: assert property (@(posedge clk) disable iff (rst)
      cfg_q[MODE_HI:MODE_LO] == MODE_OFF);
  end

endmodule

// File: rtl/pmpcfg_bank.sv
module pmpcfg_bank
  import pmpcfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter bit PMP_OFF     = 1'b0,
  localparam int WORDS      = (NUM_ENTRIES + LANES - 1) / LANES,
  localparam int WIDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          csr_we,
  input  logic [WIDX_W-1:0]             csr_widx,
  input  logic [LANES*BYTE_W-1:0]       csr_wdata,
  input  logic [LANES-1:0]              csr_wbe,
  input  logic [WIDX_W-1:0]             csr_ridx,
  output logic [LANES*BYTE_W-1:0]       csr_rdata,
  output logic [NUM_ENTRIES*BYTE_W-1:0] entry_cfg
);

  localparam int SLOTS = WORDS * LANES;

  logic [SLOTS*BYTE_W-1:0] slot_q;
  logic [SLOTS-1:0]        slot_hit;

  for (genvar e = 0; e < SLOTS; e++) begin : g_slot
    localparam int WI = e / LANES;
    localparam int LI = e % LANES;

    if (e < NUM_ENTRIES) begin : g_live
      logic [BYTE_W-1:0] wr_b;
      logic [BYTE_W-1:0] nxt_b;
      logic [BYTE_W-1:0] cur_b;

      assign wr_b        = csr_wdata[LI*BYTE_W +: BYTE_W];
      assign slot_hit[e] = csr_we && (csr_widx == WIDX_W'(WI)) && csr_wbe[LI];

      pmpcfg_legalize #(.PMP_OFF(PMP_OFF)) u_legal (
        .cur_byte (cur_b),
        .wr_byte  (wr_b),
        .nxt_byte (nxt_b)
      );

      pmpcfg_entry #(.PMP_OFF(PMP_OFF)) u_entry (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (slot_hit[e]),
        .wr_byte  (wr_b),
        .nxt_byte (nxt_b),
        .cfg_q    (cur_b)
      );

      assign slot_q[e*BYTE_W +: BYTE_W] = cur_b;
    end else begin : g_pad
      assign slot_hit[e]                = 1'b0;
      assign slot_q[e*BYTE_W +: BYTE_W] = '0;
    end
  end

  assign entry_cfg = slot_q[NUM_ENTRIES*BYTE_W-1:0];

  always_comb begin
    csr_rdata = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (int'(csr_ridx) == w) begin
        csr_rdata = slot_q[w*LANES*BYTE_W +: LANES*BYTE_W];
      end
    end
  end

  assert_one_word_R3: assert property (@(posedge clk) disable iff (rst)
    $countones(slot_hit) <= LANES);

endmodule

// File: tb/pmpcfg_bank_test.sv
module pmpcfg_bank_test;

  localparam int N  = 16;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csr_we = 1'b0;
  logic [WW-1:0] csr_widx = '0;
  logic [31:0]   csr_wdata = '0;
  logic [3:0]    csr_wbe = '0;
  logic [WW-1:0] csr_ridx = '0;
  logic [31:0]   rd_on, rd_off;
  logic [N*8-1:0] cfg_on, cfg_off;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pmpcfg_bank #(.NUM_ENTRIES(N), .PMP_OFF(1'b0)) uut (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_widx(csr_widx),
    .csr_wdata(csr_wdata), .csr_wbe(csr_wbe), .csr_ridx(csr_ridx),
    .csr_rdata(rd_on), .entry_cfg(cfg_on));

  pmpcfg_bank #(.NUM_ENTRIES(N), .PMP_OFF(1'b1)) uut_off (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_widx(csr_widx),
    .csr_wdata(csr_wdata), .csr_wbe(csr_wbe), .csr_ridx(csr_ridx),
    .csr_rdata(rd_off), .entry_cfg(cfg_off));

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    csr_we    = 1'b1;
    csr_widx  = WW'(idx);
    csr_wdata = d;
    csr_wbe   = be;
    @(negedge clk);
    csr_we    = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] on_v, output logic [31:0] off_v);
    csr_ridx = WW'(idx);
    #1;
    on_v  = rd_on;
    off_v = rd_off;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] a, b;
    do_reset();
    for (int w = 0; w < N/4; w++) begin
      rd(w, a, b);
      check("R1 word read", a, 32'h0);
    end
    check("R1 entry_cfg", cfg_on, '0);
    check("R1 entry_cfg off build", cfg_off, '0);
  endtask

  task automatic t_legal_write();
    logic [31:0] a, b;
    // lanes: 0x00, 0x03 (RW,OFF), 0x0F (RWX,TOR), 0x0D (RX,TOR)
    wr(1, 32'h0D0F_0300, 4'hF);
    rd(1, a, b);
    check("R2 legal word read", a, 32'h0D0F_0300);
    check("R2 entry 6 on entry_cfg", cfg_on[6*8 +: 8], 8'h0F);
    check("R9 mode cleared in off build", b, 32'h0507_0300);
  endtask

  task automatic t_byte_enable();
    logic [31:0] a, b;
    wr(2, 32'h0F0F_0F0F, 4'b0101);
    rd(2, a, b);
    check("R3 enabled lanes only", a, 32'h000F_000F);
    rd(1, a, b);
    check("R3 other word untouched", a, 32'h0D0F_0300);
  endtask

  task automatic t_bad_mode();
    logic [31:0] a, b;
    wr(3, 32'h0000_0018, 4'b0001);       // NAPOT over OFF
    rd(3, a, b);
    check("R4 NAPOT over OFF stays OFF", a[7:0], 8'h00);
    wr(2, 32'h0000_0011, 4'b0001);       // NA4 + R over TOR/RWX
    rd(2, a, b);
    check("R4 NA4 discarded, perms stored", a[7:0], 8'h09);
  endtask

  task automatic t_perm_reserved();
    logic [31:0] a, b;
    wr(1, 32'h0000_0200, 4'b0010);       // W only, mode OFF, over 0x03? lane1 is 0x03
    rd(1, a, b);
    check("R5 W-without-R keeps old perms", a[15:8], 8'h03);
    wr(1, 32'h0002_0000, 4'b0100);       // lane2 0x0F -> W only, mode OFF
    rd(1, a, b);
    check("R5 reserved perms kept, mode stored", a[23:16], 8'h07);
  endtask

  task automatic t_reserved_bits();
    logic [31:0] a, b;
    wr(3, 32'h0000_6100, 4'b0010);
    rd(3, a, b);
    check("R8 bits 6:5 read zero", a[15:8], 8'h01);
  endtask

  task automatic t_lane_indep();
    logic [31:0] a, b;
    wr(3, 32'h0B18_0718, 4'hF);
    rd(3, a, b);
    check("R7 mixed lanes", a, 32'h0B00_0700);
  endtask

  task automatic t_pmp_off();
    logic [31:0] a, b;
    wr(0, 32'h0808_0808, 4'hF);          // TOR only, no perms
    rd(0, a, b);
    check("R9 off build ignores mode", b, 32'h0);
    check("R2 normal build takes TOR", a, 32'h0808_0808);
    for (int e = 0; e < N; e++) begin
      check("R9 every mode zero", cfg_off[e*8+3 +: 2], 2'b00);
    end
  endtask

  task automatic t_lock();
    logic [31:0] a, b;
    wr(0, 32'h0000_0089, 4'b0001);
    rd(0, a, b);
    check("R6 lock byte stored", a[7:0], 8'h89);
    wr(0, 32'h0000_0000, 4'hF);
    rd(0, a, b);
    check("R6 locked lane ignores clear", a, 32'h0000_0089);
    wr(0, 32'h0000_0007, 4'b0001);
    rd(0, a, b);
    check("R6 locked lane ignores perms", cfg_on[7:0], 8'h89);
    do_reset();
    rd(0, a, b);
    check("R1 reset releases lock", a, 32'h0);
    wr(0, 32'h0000_0005, 4'b0001);
    rd(0, a, b);
    check("R6 writable after reset", a[7:0], 8'h05);
  endtask

  initial begin
    t_reset();
    t_legal_write();
    t_byte_enable();
    t_bad_mode();
    t_perm_reserved();
    t_reserved_bits();
    t_lane_indep();
    t_pmp_off();
    t_lock();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule